// File: doc/BRIEF.md
# Slot-Addressed Synchronous Frame Receiver

This block sits on a slave node that shares one serial data line and one timeslice strobe with several other slaves. Every node runs from the same clock as the sender, so no clock recovery is needed: bit timing comes only from counting clock cycles after a start-bit edge. Each frame on the line has one high start bit and then 32 data bits, and every bit lasts a fixed number of clocks (8 by default).

The receiver follows every frame on the line so that it can count them. The strobe clears the count and starts a new slice. Only the frame whose position in the slice equals the node's static slot index is delivered. That frame's word appears on the output together with a valid pulse one clock wide. The other frames are tracked and then dropped. No address field exists: a frame's position alone picks its receiver.

Top module: `slot_frame_rx`

## Requirements
- R1: While reset is asserted (synchronous, active low) and on the first cycle after it, `rx_valid` is 0 and `rx_word` is all zeros.
- R2: Both inputs pass through a two-flop synchroniser. A start is detected only on a low-to-high change of the synchronised data line while the receiver is idle. A line that is already high gives no start.
- R3: The start bit is checked again 4 clocks after the detected edge. If the line is low at that point, the receiver goes back to idle and the frame is not counted.
- R4: Data bit k (k = 0..31) is sampled 12 + 8k clocks after the detected edge. The first bit on the line lands in `rx_word` bit 0 (LSB first).
- R5: `rx_valid` is high for exactly one clock per accepted frame. It rises 263 clocks after the first negedge-driven cycle of the start bit, which is one clock after the last data sample.
- R6: `rx_word` changes only together with `rx_valid`. Otherwise it holds the last accepted word.
- R7: A rising edge of the synchronised strobe resets the frame index to 0. Each fully received frame then increments the index, which saturates at its maximum.
- R8: Only the frame whose index equals `slot_sel` raises `rx_valid`. All other frames leave both outputs unchanged.
- R9: A strobe rising edge abandons any frame in progress. If a data edge is seen in the same cycle as a strobe edge, the strobe wins and that data edge is ignored.
- R10: Low-to-high changes on the line inside a frame's data bits are not taken as new starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the transmitter |
| rst_n | input | 1 | Synchronous active-low reset |
| slice_strobe | input | 1 | Start-of-timeslice strobe, active on its rising edge |
| serial_in | input | 1 | Shared serial data line, idle low |
| slot_sel | input | 4 | Static slot index of this node |
| rx_word | output | 32 | Last accepted data word |
| rx_valid | output | 1 | One-clock pulse when `rx_word` is updated |

## Verification
The block is driven with slices of several frames carrying distinct words, including an alternating pattern. These show that the right position in the slice is picked and that bits come in LSB first at their centre samples. A two-clock glitch in front of real frames separates a checked start from a bare edge, because a counted glitch would shift every later slot by one. Further cases cover a strobe in the middle of a frame, a strobe in the same cycle as a start edge, and a slot index beyond the frames sent. These show the abort priority and that unselected frames leave the outputs untouched. A cycle-accurate reference model is compared with both outputs on every clock.

// File: rtl/slot_rx_pkg.sv
// Shared types for the slot-addressed frame receiver.
package slot_rx_pkg;

    // Receiver sequencing states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rx_sync.sv
// rx_sync: multi-stage synchroniser for one asynchronous-looking input,
// plus a rise detector on the synchronised level.
// Assumes STAGES >= 1; reset drives all stages low (the idle line level).
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    generate
        if (STAGES == 1) begin : g_single
            // Single stage: register the input once
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_multi
            // Multi stage: shift the input along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign level = chain[STAGES-1];

    // Keep the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;

endmodule

// File: rtl/rx_slot_track.sv
// rx_slot_track: counts completed frames inside a timeslice and flags
// whether the frame finishing now belongs to this node's slot.
// Assumes clear and advance come from the same clock domain; clear wins.
module rx_slot_track #(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [SLOT_W-1:0] slot_sel,
    output logic [SLOT_W:0]   frame_idx,
    output logic              slot_hit
);
    localparam int IDX_W = SLOT_W + 1;
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    // Frame index: cleared by the strobe, saturating increment per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_idx <= '0;
        end else if (clear) begin
            frame_idx <= '0;
        end else if (advance && frame_idx != IDX_MAX) begin
            frame_idx <= frame_idx + 1'b1;
        end
    end

    assign slot_hit = (frame_idx == {1'b0, slot_sel});

endmodule

// File: rtl/rx_frame_fsm.sv
// rx_frame_fsm: start-bit check and centre-of-cell sampling of one frame.
// Assumes the line input is already synchronised; all offsets are counted
// from the cycle in which line_rise is seen while idle. Bits shift in LSB
// first. frame_done is high in the cycle of the last data sample and
// word_next then holds the complete word including that sample.
module rx_frame_fsm
    import slot_rx_pkg::*;
#(
    parameter int BIT_CLKS  = 8,
    parameter int DATA_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort,
    input  logic                 line,
    input  logic                 line_rise,
    output logic                 busy,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] word_next
);
    localparam int HALF   = BIT_CLKS / 2;
    localparam int CNT_W  = $clog2(BIT_CLKS + 1);
    localparam int BIT_W  = $clog2(DATA_BITS) + 1;
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BIT_CLKS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

    rx_state_e            state;
    logic [CNT_W-1:0]     clk_cnt;
    logic [BIT_W-1:0]     bit_cnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 sample_now;

    assign sample_now = (state == RX_DATA) && (clk_cnt == CNT_FULL);
    assign frame_done = sample_now && (bit_cnt == BIT_LAST) && !abort;
    assign word_next  = {line, shreg[DATA_BITS-1:1]};
    assign busy       = (state != RX_IDLE);

    // Sequencing: idle -> start check -> data sampling -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            clk_cnt <= '0;
            bit_cnt <= '0;
        end else if (abort) begin
            state   <= RX_IDLE;
            clk_cnt <= '0;
            bit_cnt <= '0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (line_rise) begin
                        state   <= RX_START;
                        clk_cnt <= CNT_ONE;
                    end
                end
                RX_START: begin
                    if (clk_cnt == CNT_HALF) begin
                        clk_cnt <= line ? CNT_ONE : '0;
                        bit_cnt <= '0;
                        state   <= line ? RX_DATA : RX_IDLE;
                    end else begin
                        clk_cnt <= clk_cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (sample_now) begin
                        clk_cnt <= CNT_ONE;
                        if (bit_cnt == BIT_LAST) begin
                            bit_cnt <= '0;
                            state   <= RX_IDLE;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else begin
                        clk_cnt <= clk_cnt + 1'b1;
                    end
                end
                default: begin
                    state   <= RX_IDLE;
                    clk_cnt <= '0;
                    bit_cnt <= '0;
                end
            endcase
        end
    end

    // Shift register: take one bit at each cell centre, LSB first
    always_ff @(posedge clk) begin
        if (!rst_n)          shreg <= '0;
        else if (sample_now) shreg <= word_next;
    end

endmodule

// File: rtl/slot_frame_rx.sv
// slot_frame_rx: slave-side receiver for one slot of a timesliced serial
// line. Assumes the transmitter shares this clock, the line idles low,
// and slot_sel changes only while the line is quiet.
module slot_frame_rx #(
    parameter int BIT_CLKS    = 8,
    parameter int DATA_BITS   = 32,
    parameter int SLOT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slice_strobe,
    input  logic                 serial_in,
    input  logic [SLOT_W-1:0]    slot_sel,
    output logic [DATA_BITS-1:0] rx_word,
    output logic                 rx_valid
);
    logic                 line_lvl, line_rise;
    logic                 strobe_lvl, strobe_rise;
    logic                 fsm_busy, frame_done, slot_hit;
    logic [DATA_BITS-1:0] word_next;
    logic [SLOT_W:0]      frame_idx;

    rx_sync #(.STAGES(SYNC_STAGES)) u_line_sync (
        .clk(clk), .rst_n(rst_n), .din(serial_in),
        .level(line_lvl), .rise(line_rise)
    );

    rx_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk(clk), .rst_n(rst_n), .din(slice_strobe),
        .level(strobe_lvl), .rise(strobe_rise)
    );

    rx_frame_fsm #(.BIT_CLKS(BIT_CLKS), .DATA_BITS(DATA_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .abort(strobe_rise),
        .line(line_lvl), .line_rise(line_rise),
        .busy(fsm_busy), .frame_done(frame_done), .word_next(word_next)
    );

    rx_slot_track #(.SLOT_W(SLOT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .clear(strobe_rise),
        .advance(frame_done), .slot_sel(slot_sel),
        .frame_idx(frame_idx), .slot_hit(slot_hit)
    );

    // Output register: deliver the word of the matching slot only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= frame_done && slot_hit;
            if (frame_done && slot_hit) rx_word <= word_next;
        end
    end

endmodule

// File: rtl/slot_frame_rx_chk.sv
// slot_frame_rx_chk: temporal checks on the receiver, bound to the top.
// Keeps its own count of busy cycles to check the sampling window.
module slot_frame_rx_chk #(
    parameter int BIT_CLKS  = 8,
    parameter int DATA_BITS = 32,
    parameter int SLOT_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic [DATA_BITS-1:0] rx_word,
    input logic                 busy,
    input logic                 strobe_rise,
    input logic [SLOT_W:0]      frame_idx,
    input logic [SLOT_W-1:0]    slot_sel
);
    localparam int SPAN = BIT_CLKS / 2 + BIT_CLKS * DATA_BITS;
    logic [15:0] busy_age;

    // Count consecutive busy cycles since the accepted edge
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_age <= '0;
        else if (busy) busy_age <= busy_age + 1'b1;
        else           busy_age <= '0;
    end

    // R5
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));

    // R8
    slot_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(frame_idx) == {1'b0, slot_sel});

    // R4
    sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy_age == 16'(SPAN));

    // R9
    strobe_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> !busy);

endmodule

bind slot_frame_rx slot_frame_rx_chk #(
    .BIT_CLKS(BIT_CLKS), .DATA_BITS(DATA_BITS), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .busy(fsm_busy), .strobe_rise(strobe_rise),
    .frame_idx(frame_idx), .slot_sel(slot_sel)
);

// File: tb/slot_frame_rx_bench.sv
// Bench for slot_frame_rx: behavioural reference model compared every
// clock, plus scenario checks against hand-computed words and latencies.
module slot_frame_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slice_strobe = 1'b0;
    logic        serial_in = 1'b0;
    logic [3:0]  slot_sel = 4'd0;
    logic [31:0] rx_word;
    logic        rx_valid;

    int checks = 0, errors = 0;
    int cyc = 0, valid_cnt = 0, valid_cyc = 0, start_cyc = 0;
    bit ended = 0;

    slot_frame_rx u_slot_frame_rx (
        .clk(clk), .rst_n(rst_n), .slice_strobe(slice_strobe),
        .serial_in(serial_in), .slot_sel(slot_sel),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference model state
    logic hq[$];
    logic sq[$];
    int mode = 0, t = 0, fidx = 0;
    logic [31:0] sh = '0, exp_word = '0;
    logic exp_valid = 1'b0;

    always @(posedge clk) begin
        logic s, sp, st, stp;
        cyc++;
        exp_valid = 1'b0;
        if (!rst_n) begin
            hq = '{1'b0, 1'b0, 1'b0, 1'b0};
            sq = '{1'b0, 1'b0, 1'b0, 1'b0};
            mode = 0; t = 0; fidx = 0; exp_word = '0;
        end else begin
            hq.push_front(serial_in);
            sq.push_front(slice_strobe);
            s = hq[2]; sp = hq[3]; st = sq[2]; stp = sq[3];
            void'(hq.pop_back());
            void'(sq.pop_back());
            if (st && !stp) begin
                fidx = 0; mode = 0;
            end else if (mode == 0) begin
                if (s && !sp) begin mode = 1; t = 0; end
            end else if (mode == 1) begin
                t++;
                if (t == 4) mode = s ? 2 : 0;
            end else begin
                t++;
                if (t >= 12 && (t - 12) % 8 == 0) begin
                    sh = {s, sh[31:1]};
                    if ((t - 12) / 8 == 31) begin
                        if (fidx == int'(slot_sel)) begin
                            exp_valid = 1'b1;
                            exp_word  = sh;
                        end
                        if (fidx < 31) fidx++;
                        mode = 0;
                    end
                end
            end
        end
    end

    // Compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (!ended) begin
            checks++;
            if (rx_valid !== exp_valid) begin
                errors++;
                $display("FAIL R5 cycle %0d rx_valid actual %b expected %b", cyc, rx_valid, exp_valid);
            end
            checks++;
            if (rx_word !== exp_word) begin
                errors++;
                $display("FAIL R4 cycle %0d rx_word actual %h expected %h", cyc, rx_word, exp_word);
            end
            if (rx_valid) begin
                valid_cnt++;
                valid_cyc = cyc;
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_word(input string req, input logic [31:0] expw);
        checks++;
        if (rx_word !== expw) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, rx_word, expw);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe;
        @(negedge clk);
        serial_in = 1'b0;
        slice_strobe = 1'b1;
        idle(2);
        slice_strobe = 1'b0;
        idle(6);
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        start_cyc = cyc;
        serial_in = 1'b1;
        idle(8);
        for (int b = 0; b < 32; b++) begin
            serial_in = w[b];
            idle(8);
        end
        serial_in = 1'b0;
        idle(10);
    endtask

    task automatic finish_run;
        ended = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual cycle %0d expected end before 150000", cyc);
        finish_run();
    end

    initial begin
        int base;
        idle(4);
        // R1: reset state
        check("R1 valid in reset", int'(rx_valid), 0);
        check_word("R1 word in reset", 32'h0);
        @(negedge clk) rst_n = 1'b1;
        check("R1 valid after reset", int'(rx_valid), 0);
        idle(4);

        // R7 R8: slot 2 of four frames
        slot_sel = 4'd2;
        strobe();
        base = valid_cnt;
        send(32'h11111111); send(32'h22222222);
        send(32'hDEADBEEF); send(32'h44444444);
        idle(4);
        check("R8 one valid for slot 2", valid_cnt - base, 1);
        check_word("R7 third frame taken for slot 2", 32'hDEADBEEF);

        // R4 R5 R6: slot 0, bit order and latency, later frame ignored
        slot_sel = 4'd0;
        strobe();
        base = valid_cnt;
        send(32'hA5A50F0F);
        check("R5 latency start to valid", valid_cyc - start_cyc, 263);
        check_word("R4 LSB-first word", 32'hA5A50F0F);
        send(32'h0BADF00D);
        check("R6 second frame not delivered", valid_cnt - base, 1);
        check_word("R6 word held", 32'hA5A50F0F);

        // R3 R10: glitch is not a frame; slot 1 is the second real frame
        slot_sel = 4'd1;
        strobe();
        base = valid_cnt;
        @(negedge clk) serial_in = 1'b1;
        idle(2);
        serial_in = 1'b0;
        idle(12);
        send(32'h00000001);
        send(32'h80000000);
        check("R3 glitch not counted", valid_cnt - base, 1);
        check_word("R3 slot 1 word", 32'h80000000);

        // R9: strobe in mid-frame aborts it
        slot_sel = 4'd0;
        strobe();
        base = valid_cnt;
        @(negedge clk) serial_in = 1'b1;
        idle(8);
        serial_in = 1'b0;
        idle(40);
        serial_in = 1'b1;
        idle(50);
        strobe();
        send(32'h12345678);
        check("R9 abort then slot 0", valid_cnt - base, 1);
        check_word("R9 word after abort", 32'h12345678);

        // R9 R2: strobe and start edge together; steady high gives no start
        base = valid_cnt;
        @(negedge clk);
        slice_strobe = 1'b1;
        serial_in = 1'b1;
        idle(2);
        slice_strobe = 1'b0;
        idle(300);
        check("R2 no start from steady high", valid_cnt - base, 0);
        serial_in = 1'b0;
        idle(10);
        send(32'hFFFFFFFF);
        check("R9 next frame is index 0", valid_cnt - base, 1);
        check_word("R9 all ones word", 32'hFFFFFFFF);

        // R8: slot beyond the frames sent
        slot_sel = 4'd5;
        strobe();
        base = valid_cnt;
        send(32'h0); send(32'h13579BDF); send(32'h2468ACE0);
        idle(6);
        check("R8 no valid for slot 5", valid_cnt - base, 0);
        check_word("R8 word unchanged", 32'hFFFFFFFF);

        finish_run();
    end

endmodule